// File: doc/BRIEF.md
# Priority Interrupt Controller Register Interface

This block is the software-facing front end of one eight-line priority interrupt controller. It sits on a byte-wide bus that has a single address bit. It turns each write into one of three things: a step of the start-up programming sequence, an operating command, or a mask update. It turns each read into a register readback or a poll acknowledge.

The block holds the mask, the rotating priority base, the nesting, automatic-completion and rotation mode flags, and the vector base. It exposes these as levels to the priority core. In the cycle of the write or read that causes them, it drives single-cycle clear strobes for the in-service and request bits, plus a strobe that clears the edge-remembered levels.

The priority core outside this block captures requests and picks the winner. It returns the in-service and request vectors, the per-line trigger kind and the current winning line. Only non-specific end-of-interrupt needs its own search over the in-service bits, and that search lives inside this block.

Top module: `irq_regif`

## Requirements
- R1: A write at address 0 with bit 4 set starts programming. In the same cycle it pulses `hist_clr_o` and drives `irr_clr_o` to the inverse of `trig_level`, so that only level-kind requests survive. After the edge, the mask, the priority base, the special mask and the read select are zero, and `init_busy_o` is 1.
- R2: After a start byte, the first write at address 1 loads the vector base from data bits 7:3. The second write at address 1 is discarded. A third write at address 1 is expected only if bit 0 of the start byte was 1. `init_busy_o` stays 1 until the last expected byte, and none of these bytes changes the mask.
- R3: In the optional third byte, bit 4 sets special nesting and bit 1 sets automatic completion. A start byte with bit 0 clear clears both flags at once.
- R4: When `init_busy_o` is 0, a write at address 1 loads the mask from the data byte.
- R5: A write at address 0 with bits 4:3 = 01 is a read/poll command. Bit 2 = 1 arms polling. Bit 1 = 1 copies bit 0 into the read select. Bit 6 = 1 copies bit 5 into the special mask. A qualifier bit of 0 leaves its target unchanged.
- R6: A write at address 0 with bits 4:3 = 00 carries an operation code in bits 7:5. Code 4 sets the rotate-on-automatic-completion flag and code 0 clears it. Code 2 changes no output and gives no strobe.
- R7: Code 1 pulses `isr_clr_o` for the in-service line that is found first when searching upward from the priority base, wrapping modulo 8. With no in-service line, no bit is pulsed.
- R8: Code 5 does what code 1 does and also sets the priority base to that line plus 1, modulo 8. With no in-service line, the base is unchanged.
- R9: Code 3 pulses `isr_clr_o` for the line in data bits 2:0. Code 7 does the same and also sets the priority base to that line plus 1, modulo 8.
- R10: Code 6 sets the priority base to data bits 2:0 plus 1, modulo 8, and gives no strobe.
- R11: A read returns its data on `bus_rdata` one cycle after the read strobe, and the value then holds until the next read. Address 1 returns the mask. Address 0 returns the in-service vector when the read select is 1, and the request vector when it is 0.
- R12: When polling is armed, the next read returns the winning line number and disarms polling, whatever the address. If a winner exists, the same read pulses that line in both `isr_clr_o` and `irr_clr_o`. With no winner it returns 7 and gives no strobe.
- R13: After reset, every register output is zero, `init_busy_o` is 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Port address bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| req_lines | input | 8 | Request vector from the core |
| svc_lines | input | 8 | In-service vector from the core |
| trig_level | input | 8 | Per-line trigger kind, 1 = level |
| win_valid | input | 1 | Core has a winning line |
| win_line | input | 3 | Winning line number |
| mask_o | output | 8 | Mask register |
| prio_base_o | output | 3 | Line with the highest priority |
| spec_mask_o | output | 1 | Special mask flag |
| spec_nest_o | output | 1 | Special nesting flag |
| auto_eoi_o | output | 1 | Automatic completion flag |
| rot_aeoi_o | output | 1 | Rotate on automatic completion flag |
| vec_base_o | output | 5 | Vector base |
| init_busy_o | output | 1 | Programming sequence in progress |
| isr_clr_o | output | 8 | In-service clear strobes |
| irr_clr_o | output | 8 | Request clear strobes |
| hist_clr_o | output | 1 | Clear edge-remembered levels |

## Verification
The assertions take for granted that the bus never raises the read and write strobes in the same cycle, and that the core holds `win_line` and `svc_lines` steady around a bus operation. The bench drives every access from a task that raises a single strobe for one cycle. It changes the core-side vectors only between accesses. The bench sweeps every pair of priority base and in-service pattern for both non-specific forms, every mask value, every vector base, and every line for the specific and rotate forms. It predicts each result by arithmetic.

// File: rtl/irq_regif_pkg.sv
package irq_regif_pkg;

   typedef enum logic [1:0] {
      IS_READY = 2'd0,
      IS_BASE  = 2'd1,
      IS_CASC  = 2'd2,
      IS_MODE  = 2'd3
   } init_st_t;

   typedef enum logic [2:0] {
      OP_ROT_CLR = 3'd0,
      OP_NS_EOI  = 3'd1,
      OP_NOP     = 3'd2,
      OP_SP_EOI  = 3'd3,
      OP_ROT_SET = 3'd4,
      OP_NS_ROT  = 3'd5,
      OP_SET_PRI = 3'd6,
      OP_SP_ROT  = 3'd7
   } op_t;

   localparam int B_START  = 4;
   localparam int B_CMD3   = 3;
   localparam int B_POLL   = 2;
   localparam int B_RSEL_EN = 1;
   localparam int B_RSEL   = 0;
   localparam int B_SMM_EN = 6;
   localparam int B_SMM    = 5;
   localparam int B_WANT3  = 0;
   localparam int B_NEST   = 4;
   localparam int B_AEOI   = 1;
   localparam int SPURIOUS = 7;

endpackage

// File: rtl/irq_rot_find.sv
module irq_rot_find #(
   parameter int LINES = 8,
   parameter int LW    = $clog2(LINES)
) (
   input  logic [LINES-1:0] vec,
   input  logic [LW-1:0]    base,
   output logic             hit,
   output logic [LW-1:0]    line
);

   logic [2*LINES-1:0] dbl;
   logic [LINES-1:0]   rot;
   logic [LW-1:0]      idx;
   logic [LINES:0]     seen;
   logic [LINES-1:0]   first;

   assign dbl = {vec, vec} >> base;
   assign rot = dbl[LINES-1:0];

   assign seen[0] = 1'b0;
   for (genvar k = 0; k < LINES; k++) begin : g_chain
      assign first[k]  = rot[k] & ~seen[k];
      assign seen[k+1] = seen[k] | rot[k];
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < LINES; k++) begin
         if (first[k]) idx = LW'(k);
      end
   end

   assign hit  = seen[LINES];
   assign line = idx + base;

   // R7
   always_comb begin
      found_set_chk: assert (!hit || vec[line]);
   end

endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
   import irq_regif_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     want_mode,
   input  logic     port_wr,
   output init_st_t state_o,
   output logic     base_ld,
   output logic     mode_ld,
   output logic     mask_ld
);

   init_st_t st_q;
   logic     need3_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= IS_READY;
         need3_q <= 1'b0;
      end else if (start) begin
         st_q    <= IS_BASE;
         need3_q <= want_mode;
      end else if (port_wr) begin
         unique case (st_q)
            IS_BASE: st_q <= IS_CASC;
            IS_CASC: st_q <= need3_q ? IS_MODE : IS_READY;
            IS_MODE: st_q <= IS_READY;
            default: st_q <= IS_READY;
         endcase
      end
   end

   assign state_o = st_q;
   assign base_ld = port_wr && !start && st_q == IS_BASE;
   assign mode_ld = port_wr && !start && st_q == IS_MODE;
   assign mask_ld = port_wr && !start && st_q == IS_READY;

   // R2
   base_then_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_ld |=> st_q == IS_CASC);

   // R2
   casc_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && st_q == IS_CASC && !need3_q) |=> st_q == IS_READY);

endmodule

// File: rtl/irq_readback.sv
module irq_readback
   import irq_regif_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LINES = 8,
   parameter int LW    = $clog2(LINES)
) (
   input  logic             addr,
   input  logic             poll,
   input  logic             rdsel,
   input  logic [LINES-1:0] req,
   input  logic [LINES-1:0] svc,
   input  logic [LINES-1:0] mask,
   input  logic             win_valid,
   input  logic [LW-1:0]    win_line,
   output logic [DW-1:0]    data
);

   always_comb begin
      if (poll) begin
         data = win_valid ? DW'(win_line) : DW'(SPURIOUS);
      end else if (addr) begin
         data = DW'(mask);
      end else if (rdsel) begin
         data = DW'(svc);
      end else begin
         data = DW'(req);
      end
   end

endmodule

// File: rtl/irq_regif.sv
module irq_regif
   import irq_regif_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LINES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_addr,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [DW-1:0]              bus_wdata,
   output logic [DW-1:0]              bus_rdata,
   input  logic [LINES-1:0]           req_lines,
   input  logic [LINES-1:0]           svc_lines,
   input  logic [LINES-1:0]           trig_level,
   input  logic                       win_valid,
   input  logic [$clog2(LINES)-1:0]   win_line,
   output logic [LINES-1:0]           mask_o,
   output logic [$clog2(LINES)-1:0]   prio_base_o,
   output logic                       spec_mask_o,
   output logic                       spec_nest_o,
   output logic                       auto_eoi_o,
   output logic                       rot_aeoi_o,
   output logic [DW-$clog2(LINES)-1:0] vec_base_o,
   output logic                       init_busy_o,
   output logic [LINES-1:0]           isr_clr_o,
   output logic [LINES-1:0]           irr_clr_o,
   output logic                       hist_clr_o
);

   localparam int LW = $clog2(LINES);
   localparam int VW = DW - LW;

   if (LINES < 2 || LINES > 8 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two from 2 to 8");
   end
   if (DW != 8) begin : g_bad_dw
      $error("command decode needs an 8-bit data port");
   end

   // write decode
   logic     wr0, wr1, is_start, is_rp, is_op;
   op_t      op;
   logic [LW-1:0] wline;

   assign wr0      = bus_wr & ~bus_addr;
   assign wr1      = bus_wr &  bus_addr;
   assign is_start = wr0 &  bus_wdata[B_START];
   assign is_rp    = wr0 & ~bus_wdata[B_START] &  bus_wdata[B_CMD3];
   assign is_op    = wr0 & ~bus_wdata[B_START] & ~bus_wdata[B_CMD3];
   assign op       = op_t'(bus_wdata[7:5]);
   assign wline    = bus_wdata[LW-1:0];

   // state
   logic [LINES-1:0] mask_q;
   logic [LW-1:0]    base_q;
   logic             smm_q, nest_q, aeoi_q, rot_q, rdsel_q, poll_q;
   logic [VW-1:0]    vbase_q;
   logic [DW-1:0]    rdata_q;

   init_st_t ist;
   logic     base_ld, mode_ld, mask_ld;

   irq_init_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (is_start),
      .want_mode (bus_wdata[B_WANT3]),
      .port_wr   (wr1),
      .state_o   (ist),
      .base_ld   (base_ld),
      .mode_ld   (mode_ld),
      .mask_ld   (mask_ld)
   );

   logic          ns_hit;
   logic [LW-1:0] ns_line;

   irq_rot_find #(.LINES(LINES), .LW(LW)) u_find (
      .vec  (svc_lines),
      .base (base_q),
      .hit  (ns_hit),
      .line (ns_line)
   );

   logic [DW-1:0] rb_data;

   irq_readback #(.DW(DW), .LINES(LINES), .LW(LW)) u_rb (
      .addr      (bus_addr),
      .poll      (poll_q),
      .rdsel     (rdsel_q),
      .req       (req_lines),
      .svc       (svc_lines),
      .mask      (mask_q),
      .win_valid (win_valid),
      .win_line  (win_line),
      .data      (rb_data)
   );

   logic poll_take;
   assign poll_take = bus_rd & poll_q & win_valid;

   // strobes
   always_comb begin
      isr_clr_o  = '0;
      irr_clr_o  = '0;
      hist_clr_o = 1'b0;
      if (is_start) begin
         hist_clr_o = 1'b1;
         irr_clr_o  = ~trig_level;
      end
      if (is_op) begin
         unique case (op)
            OP_NS_EOI, OP_NS_ROT: if (ns_hit) isr_clr_o = LINES'(1) << ns_line;
            OP_SP_EOI, OP_SP_ROT: isr_clr_o = LINES'(1) << wline;
            default: ;
         endcase
      end
      if (poll_take) begin
         isr_clr_o = isr_clr_o | (LINES'(1) << win_line);
         irr_clr_o = irr_clr_o | (LINES'(1) << win_line);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         base_q  <= '0;
         smm_q   <= 1'b0;
         nest_q  <= 1'b0;
         aeoi_q  <= 1'b0;
         rot_q   <= 1'b0;
         rdsel_q <= 1'b0;
         poll_q  <= 1'b0;
         vbase_q <= '0;
         rdata_q <= '0;
      end else begin
         if (is_start) begin
            mask_q  <= '0;
            base_q  <= '0;
            smm_q   <= 1'b0;
            rdsel_q <= 1'b0;
            if (!bus_wdata[B_WANT3]) begin
               nest_q <= 1'b0;
               aeoi_q <= 1'b0;
            end
         end
         if (base_ld) vbase_q <= bus_wdata[DW-1:LW];
         if (mode_ld) begin
            nest_q <= bus_wdata[B_NEST];
            aeoi_q <= bus_wdata[B_AEOI];
         end
         if (mask_ld) mask_q <= bus_wdata[LINES-1:0];
         if (is_rp) begin
            if (bus_wdata[B_POLL])    poll_q  <= 1'b1;
            if (bus_wdata[B_RSEL_EN]) rdsel_q <= bus_wdata[B_RSEL];
            if (bus_wdata[B_SMM_EN])  smm_q   <= bus_wdata[B_SMM];
         end
         if (is_op) begin
            unique case (op)
               OP_ROT_CLR: rot_q <= 1'b0;
               OP_ROT_SET: rot_q <= 1'b1;
               OP_NS_ROT:  if (ns_hit) base_q <= ns_line + 1'b1;
               OP_SET_PRI, OP_SP_ROT: base_q <= wline + 1'b1;
               default: ;
            endcase
         end
         if (bus_rd) begin
            rdata_q <= rb_data;
            poll_q  <= 1'b0;
         end
      end
   end

   assign bus_rdata   = rdata_q;
   assign mask_o      = mask_q;
   assign prio_base_o = base_q;
   assign spec_mask_o = smm_q;
   assign spec_nest_o = nest_q;
   assign auto_eoi_o  = aeoi_q;
   assign rot_aeoi_o  = rot_q;
   assign vec_base_o  = vbase_q;
   assign init_busy_o = (ist != IS_READY);

   // bus rule assumed by the checks below
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   // R1
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_start |=> (mask_o == '0 && prio_base_o == '0 && !spec_mask_o && init_busy_o));

   // R4
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !init_busy_o) |=> mask_o == $past(bus_wdata[LINES-1:0]));

   // R7
   ns_clear_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_op && op == OP_NS_EOI) |->
         ((isr_clr_o & ~svc_lines) == '0 && $countones(isr_clr_o) == int'(|svc_lines)));

   // R8
   ns_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_op && op == OP_NS_ROT && ns_hit) |=> prio_base_o == LW'($past(ns_line) + 1'b1));

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R12
   poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && poll_q) |=> !poll_q);

endmodule

// File: tb/irq_regif_test.sv
`timescale 1ns/100ps
module irq_regif_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] req_lines = '0, svc_lines = '0, trig_level = '0;
   logic       win_valid = 1'b0;
   logic [2:0] win_line = '0;
   logic [7:0] mask_o;
   logic [2:0] prio_base_o;
   logic       spec_mask_o, spec_nest_o, auto_eoi_o, rot_aeoi_o;
   logic [4:0] vec_base_o;
   logic       init_busy_o;
   logic [7:0] isr_clr_o, irr_clr_o;
   logic       hist_clr_o;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic [7:0] cap_isr, cap_irr;
   logic       cap_hist;
   logic [7:0] rd_val;

   always #2.5 clk = ~clk;

   irq_regif uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_lines(req_lines),
      .svc_lines(svc_lines), .trig_level(trig_level), .win_valid(win_valid),
      .win_line(win_line), .mask_o(mask_o), .prio_base_o(prio_base_o),
      .spec_mask_o(spec_mask_o), .spec_nest_o(spec_nest_o), .auto_eoi_o(auto_eoi_o),
      .rot_aeoi_o(rot_aeoi_o), .vec_base_o(vec_base_o), .init_busy_o(init_busy_o),
      .isr_clr_o(isr_clr_o), .irr_clr_o(irr_clr_o), .hist_clr_o(hist_clr_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #1;
      cap_isr = isr_clr_o; cap_irr = irr_clr_o; cap_hist = hist_clr_o;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      cap_isr = isr_clr_o; cap_irr = irr_clr_o; cap_hist = hist_clr_o;
      @(negedge clk);
      bus_rd = 1'b0;
      rd_val = bus_rdata;
   endtask

   function automatic logic [3:0] exp_find(input logic [7:0] p, input int o);
      for (int k = 0; k < 8; k++) begin
         if (p[(o + k) % 8]) return 4'((o + k) % 8);
      end
      return 4'd8;
   endfunction

   task automatic set_base(input int o);
      do_wr(1'b0, 8'hC0 | 8'((o + 7) % 8));
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      chk("R13 mask", mask_o, 0);
      chk("R13 base", prio_base_o, 0);
      chk("R13 flags", {spec_mask_o, spec_nest_o, auto_eoi_o, rot_aeoi_o, init_busy_o}, 0);
      chk("R13 vbase", vec_base_o, 0);
      chk("R13 rdata", bus_rdata, 0);

      // R2 R3 vector base sweep with announced third byte
      for (int b = 0; b < 32; b++) begin
         logic [7:0] mode;
         mode = (b[0] ? 8'h10 : 8'h00) | (b[1] ? 8'h02 : 8'h00);
         do_wr(1'b0, 8'h11);
         chk("R2 busy after start", init_busy_o, 1);
         do_wr(1'b1, {5'(b), 3'b101});
         do_wr(1'b1, 8'hFF);
         chk("R2 busy before third", init_busy_o, 1);
         chk("R2 mask untouched", mask_o, 0);
         do_wr(1'b1, mode);
         chk("R2 vbase", vec_base_o, 32'(b));
         chk("R3 nest", spec_nest_o, 32'(b[0]));
         chk("R3 aeoi", auto_eoi_o, 32'(b[1]));
         chk("R2 busy done", init_busy_o, 0);
      end

      // R3 no third byte clears modes; R2 short sequence
      do_wr(1'b0, 8'h11); do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h12);
      chk("R3 set both", {spec_nest_o, auto_eoi_o}, 2'b11);
      do_wr(1'b0, 8'h10);
      chk("R3 cleared", {spec_nest_o, auto_eoi_o}, 0);
      do_wr(1'b1, 8'h50); do_wr(1'b1, 8'h33);
      chk("R2 short done", init_busy_o, 0);
      chk("R2 short vbase", vec_base_o, 5'h0A);
      chk("R2 short mask", mask_o, 0);

      // R4 R11 mask sweep with readback
      for (int m = 0; m < 256; m++) begin
         do_wr(1'b1, 8'(m));
         chk("R4 mask", mask_o, 32'(m));
         do_rd(1'b1);
         chk("R11 mask read", rd_val, 32'(m));
      end

      // R5 R11 read select
      req_lines = 8'h3C; svc_lines = 8'hC1;
      do_wr(1'b0, 8'h0B);
      do_rd(1'b0);
      chk("R11 isr read", rd_val, 8'hC1);
      do_wr(1'b0, 8'h08);
      do_rd(1'b0);
      chk("R5 rdsel kept", rd_val, 8'hC1);
      do_wr(1'b0, 8'h0A);
      do_rd(1'b0);
      chk("R11 irr read", rd_val, 8'h3C);
      req_lines = 8'h77;
      chk("R11 rdata held", bus_rdata, 8'h3C);

      // R5 special mask
      do_wr(1'b0, 8'h68);
      chk("R5 smm set", spec_mask_o, 1);
      do_wr(1'b0, 8'h28);
      chk("R5 smm kept", spec_mask_o, 1);
      do_wr(1'b0, 8'h48);
      chk("R5 smm clear", spec_mask_o, 0);

      // R1 start clears state and strobes
      do_wr(1'b1, 8'hA5); do_wr(1'b0, 8'h6B); set_base(3);
      trig_level = 8'h96;
      do_wr(1'b0, 8'h10);
      chk("R1 hist", cap_hist, 1);
      chk("R1 irr clr", cap_irr, 8'h69);
      chk("R1 isr clr", cap_isr, 0);
      chk("R1 cleared", {mask_o, 5'(prio_base_o), spec_mask_o, init_busy_o}, {8'h00, 5'h0, 1'b0, 1'b1});
      do_rd(1'b0);
      chk("R1 rdsel cleared", rd_val, 8'h77);
      do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);

      // R6 rotation flag and no-op code
      do_wr(1'b0, 8'h80);
      chk("R6 rot set", rot_aeoi_o, 1);
      set_base(5);
      svc_lines = 8'hFF;
      do_wr(1'b0, 8'h40);
      chk("R6 nop strobe", cap_isr, 0);
      chk("R6 nop state", {rot_aeoi_o, 5'(prio_base_o)}, {1'b1, 5'd5});
      do_wr(1'b0, 8'h00);
      chk("R6 rot clr", rot_aeoi_o, 0);

      // R7 R8 non-specific forms, all bases and patterns
      for (int o = 0; o < 8; o++) begin
         for (int p = 0; p < 256; p++) begin
            logic [3:0] f;
            f = exp_find(8'(p), o);
            svc_lines = 8'(p);
            set_base(o);
            do_wr(1'b0, 8'h20);
            chk("R7 ns eoi", cap_isr, (f == 8) ? 0 : (32'd1 << f));
            chk("R7 base kept", prio_base_o, 32'(o));
            set_base(o);
            do_wr(1'b0, 8'hA0);
            chk("R8 ns rot strobe", cap_isr, (f == 8) ? 0 : (32'd1 << f));
            chk("R8 ns rot base", prio_base_o, (f == 8) ? 32'(o) : 32'((f + 1) % 8));
         end
      end

      // R9 R10 specific and set-priority forms
      svc_lines = 8'h00;
      for (int l = 0; l < 8; l++) begin
         set_base(2);
         do_wr(1'b0, 8'h60 | 8'(l));
         chk("R9 sp eoi", cap_isr, 32'd1 << l);
         chk("R9 sp base kept", prio_base_o, 2);
         do_wr(1'b0, 8'hE0 | 8'(l));
         chk("R9 sp rot", {cap_isr, 5'(prio_base_o)}, {8'(1 << l), 5'((l + 1) % 8)});
         do_wr(1'b0, 8'hC0 | 8'(l) | 8'h18 & 8'h00);
         chk("R10 set pri", {cap_isr, 5'(prio_base_o)}, {8'h00, 5'((l + 1) % 8)});
      end

      // R12 poll
      req_lines = 8'h5A; svc_lines = 8'h00;
      for (int l = 0; l < 8; l++) begin
         win_valid = 1'b1; win_line = 3'(l);
         do_wr(1'b0, 8'h0C);
         do_rd(1'(l % 2));
         chk("R12 poll line", rd_val, 32'(l));
         chk("R12 poll strobes", {cap_isr, cap_irr}, {8'(1 << l), 8'(1 << l)});
         do_rd(1'b1);
         chk("R12 disarmed", {rd_val, cap_isr, cap_irr}, {mask_o, 16'h0});
      end
      win_valid = 1'b0;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0);
      chk("R12 poll none", {rd_val, cap_isr, cap_irr}, {8'h07, 16'h0});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule